// File: doc/BRIEF.md
# Two-Master AHB-Lite Crossbar with Access Fence

This block connects two AHB-Lite masters to eight AHB-Lite slave ports. Master port 0 belongs to the processor and master port 1 belongs to a DMA engine. Each slave port owns a fixed 4 KB window. Address bits [14:12] select the port, and any set bit at or above bit 15 makes the address unmapped. When both masters address different ports, both are served in the same cycle. When both want the same port, the processor wins. The losing request is accepted on its own master port and parked in a holding register. It is then issued as soon as the port finishes its current data phase.

A fixed permission mask stops the DMA from reaching three peripheral ports, which hold system control, configuration and timers. The processor can reach every port. A refused or unmapped transfer never reaches a slave. Instead it receives the standard two-cycle AHB error response. Read data, ready and response are returned to each master from a registered record of which port its data phase sits on. Pipelined address and data phases therefore stay paired even when slaves insert wait states.

Top module: `ahb_dual_matrix`

## Requirements
- R1: A transfer whose address has bits [31:15] all zero is forwarded only to slave port k = address[14:12]. That port's select is high for one address-phase cycle, and the address and NONSEQ/SEQ code (htrans[1]=1) are passed unchanged.
- R2: A transfer from either master whose address has any bit set at or above bit 15 selects no slave port and is answered with an error response.
- R3: The DMA permission mask is 8'b1100_0111, where bit k grants port k. A DMA transfer to port 3, 4 or 5 selects no slave port and is answered with an error response.
- R4: The processor reaches all eight ports and receives the read data of the addressed port.
- R5: An error response lasts two cycles on the master port. The first cycle has hready=0 with hresp=1, and the second has hready=1 with hresp=1.
- R6: When both masters request the same port in the same cycle, the processor's transfer is issued first. The port then stays with the current owner until that owner's data phase completes.
- R7: A request that loses arbitration is accepted and held. The master sees hready=0 until the held transfer has been issued and its data phase completes with the correct data.
- R8: Requests from the two masters to different ports are issued in the same cycle and complete in the same cycle when neither slave inserts wait states.
- R9: Each master's read data, ready and response come from the port that holds its data phase. Wait states on one port stall only the master that owns that port's data phase.
- R10: After reset both master ports show hready=1 and hresp=0, and no slave port is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_haddr | input | ADDR_W | Processor address |
| cpu_htrans | input | 2 | Processor transfer type |
| cpu_hwrite | input | 1 | Processor write flag |
| cpu_hsize | input | 3 | Processor transfer size |
| cpu_hwdata | input | DATA_W | Processor write data |
| cpu_hrdata | output | DATA_W | Read data to processor |
| cpu_hready | output | 1 | Ready to processor |
| cpu_hresp | output | 1 | Error response to processor |
| dma_haddr | input | ADDR_W | DMA address |
| dma_htrans | input | 2 | DMA transfer type |
| dma_hwrite | input | 1 | DMA write flag |
| dma_hsize | input | 3 | DMA transfer size |
| dma_hwdata | input | DATA_W | DMA write data |
| dma_hrdata | output | DATA_W | Read data to DMA |
| dma_hready | output | 1 | Ready to DMA |
| dma_hresp | output | 1 | Error response to DMA |
| slv_hsel | output | NSLV | Per-port select |
| slv_haddr | output | NSLV*ADDR_W | Per-port address, port k at bits [k*ADDR_W +: ADDR_W] |
| slv_htrans | output | NSLV*2 | Per-port transfer type |
| slv_hwrite | output | NSLV | Per-port write flag |
| slv_hsize | output | NSLV*3 | Per-port transfer size |
| slv_hwdata | output | NSLV*DATA_W | Per-port write data from the data-phase owner |
| slv_hready | output | NSLV | Per-port ready: high when the port can take an address phase |
| slv_hrdata | input | NSLV*DATA_W | Per-port read data |
| slv_hreadyout | input | NSLV | Per-port ready from the slave |
| slv_hresp | input | NSLV | Per-port error response from the slave |

## Verification
The assertions assume that each master holds its address, control and write data stable while its hready is low. They also assume that an idle slave drives hreadyout high and that no slave's hreadyout depends combinationally on its select. The bench drives each master from a task that changes signals only on the falling edge. Each task waits for hready before it moves to the next phase. The slave models are small memories with a fixed number of wait states per port (one on port 1, two on port 6) and never return errors, so every error seen at a master comes from the crossbar itself.

// File: rtl/ahb_dual_matrix.sv
module ahb_dual_matrix #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NSLV = 8,
  parameter int REGION_W = 12,
  parameter logic [NSLV-1:0] DMA_MASK = 8'b1100_0111
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        cpu_haddr,
  input  logic [1:0]               cpu_htrans,
  input  logic                     cpu_hwrite,
  input  logic [2:0]               cpu_hsize,
  input  logic [DATA_W-1:0]        cpu_hwdata,
  output logic [DATA_W-1:0]        cpu_hrdata,
  output logic                     cpu_hready,
  output logic                     cpu_hresp,
  input  logic [ADDR_W-1:0]        dma_haddr,
  input  logic [1:0]               dma_htrans,
  input  logic                     dma_hwrite,
  input  logic [2:0]               dma_hsize,
  input  logic [DATA_W-1:0]        dma_hwdata,
  output logic [DATA_W-1:0]        dma_hrdata,
  output logic                     dma_hready,
  output logic                     dma_hresp,
  output logic [NSLV-1:0]          slv_hsel,
  output logic [NSLV*ADDR_W-1:0]   slv_haddr,
  output logic [NSLV*2-1:0]        slv_htrans,
  output logic [NSLV-1:0]          slv_hwrite,
  output logic [NSLV*3-1:0]        slv_hsize,
  output logic [NSLV*DATA_W-1:0]   slv_hwdata,
  output logic [NSLV-1:0]          slv_hready,
  input  logic [NSLV*DATA_W-1:0]   slv_hrdata,
  input  logic [NSLV-1:0]          slv_hreadyout,
  input  logic [NSLV-1:0]          slv_hresp
);
  localparam int SW = $clog2(NSLV);
  localparam int TOP = REGION_W + SW;

  typedef enum logic [2:0] {DP_IDLE, DP_SLV, DP_WAIT, DP_ERR1, DP_ERR2} dp_t;

  logic [1:0][ADDR_W-1:0] l_addr, h_addr, c_addr;
  logic [1:0][1:0]        l_trans, h_trans, c_trans;
  logic [1:0]             l_write, h_write, c_write;
  logic [1:0][2:0]        l_size, h_size, c_size;
  logic [1:0][DATA_W-1:0] l_wdata, rdata;
  dp_t  [1:0]             st;
  logic [1:0][SW-1:0]     dslv, c_idx;
  logic [1:0]             rdy, rsp, c_v, c_ok;
  logic [1:0][NSLV-1:0]   want, gnt;
  logic [NSLV-1:0]        busy, own, free;

  assign l_addr  = {dma_haddr, cpu_haddr};
  assign l_trans = {dma_htrans, cpu_htrans};
  assign l_write = {dma_hwrite, cpu_hwrite};
  assign l_size  = {dma_hsize, cpu_hsize};
  assign l_wdata = {dma_hwdata, cpu_hwdata};

  assign cpu_hrdata = rdata[0];
  assign cpu_hready = rdy[0];
  assign cpu_hresp  = rsp[0];
  assign dma_hrdata = rdata[1];
  assign dma_hready = rdy[1];
  assign dma_hresp  = rsp[1];

  always_comb begin
    for (int m = 0; m < 2; m++) begin
      case (st[m])
        DP_SLV:  begin rdy[m] = slv_hreadyout[dslv[m]]; rsp[m] = slv_hresp[dslv[m]]; end
        DP_WAIT: begin rdy[m] = 1'b0; rsp[m] = 1'b0; end
        DP_ERR1: begin rdy[m] = 1'b0; rsp[m] = 1'b1; end
        DP_ERR2: begin rdy[m] = 1'b1; rsp[m] = 1'b1; end
        default: begin rdy[m] = 1'b1; rsp[m] = 1'b0; end
      endcase
      rdata[m] = slv_hrdata[int'(dslv[m])*DATA_W +: DATA_W];
      if (st[m] == DP_WAIT) begin
        c_v[m] = 1'b1;
        c_addr[m] = h_addr[m];
        c_trans[m] = h_trans[m];
        c_write[m] = h_write[m];
        c_size[m] = h_size[m];
      end else begin
        c_v[m] = rdy[m] & l_trans[m][1];
        c_addr[m] = l_addr[m];
        c_trans[m] = l_trans[m];
        c_write[m] = l_write[m];
        c_size[m] = l_size[m];
      end
      c_idx[m] = c_addr[m][REGION_W +: SW];
      c_ok[m] = ((c_addr[m] >> TOP) == '0) &&
                ((m == 1) ? DMA_MASK[c_idx[m]] : 1'b1);
    end
  end

  always_comb begin
    busy = '0;
    own = '0;
    for (int m = 0; m < 2; m++)
      if (st[m] == DP_SLV) begin
        busy[dslv[m]] = 1'b1;
        if (m == 1) own[dslv[m]] = 1'b1;
      end
    free = ~busy | slv_hreadyout;
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < NSLV; s++)
        want[m][s] = c_v[m] & c_ok[m] & (c_idx[m] == SW'(s));
    gnt[0] = want[0] & free;
    gnt[1] = want[1] & free & ~want[0];
  end

  always_comb begin
    for (int s = 0; s < NSLV; s++) begin
      slv_hsel[s] = gnt[0][s] | gnt[1][s];
      slv_haddr[s*ADDR_W +: ADDR_W] = c_addr[gnt[1][s]];
      slv_htrans[s*2 +: 2] = slv_hsel[s] ? c_trans[gnt[1][s]] : 2'b00;
      slv_hwrite[s] = c_write[gnt[1][s]];
      slv_hsize[s*3 +: 3] = c_size[gnt[1][s]];
      slv_hwdata[s*DATA_W +: DATA_W] = l_wdata[own[s]];
    end
  end
  assign slv_hready = free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= {DP_IDLE, DP_IDLE};
      dslv <= '0;
      h_addr <= '0;
      h_trans <= '0;
      h_write <= '0;
      h_size <= '0;
    end else begin
      for (int m = 0; m < 2; m++) begin
        if (st[m] == DP_ERR1) begin
          st[m] <= DP_ERR2;
        end else if (st[m] == DP_WAIT) begin
          if (|gnt[m]) begin
            st[m] <= DP_SLV;
            dslv[m] <= c_idx[m];
          end
        end else if (rdy[m]) begin
          if (!c_v[m]) begin
            st[m] <= DP_IDLE;
          end else if (!c_ok[m]) begin
            st[m] <= DP_ERR1;
          end else if (|gnt[m]) begin
            st[m] <= DP_SLV;
            dslv[m] <= c_idx[m];
          end else begin
            st[m] <= DP_WAIT;
            h_addr[m] <= l_addr[m];
            h_trans[m] <= l_trans[m];
            h_write[m] <= l_write[m];
            h_size[m] <= l_size[m];
          end
        end
      end
    end
  end

  p_cpu_err_two_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_hready && cpu_hresp) |=> (cpu_hready && cpu_hresp));
  p_dma_err_two_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_hready && dma_hresp) |=> (dma_hready && dma_hresp));

  for (genvar s = 0; s < NSLV; s++) begin : g_chk
    p_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
      slv_hsel[s] |-> (slv_haddr[s*ADDR_W + REGION_W +: SW] == SW'(s)) &&
                      ((slv_haddr[s*ADDR_W +: ADDR_W] >> TOP) == '0) &&
                      slv_htrans[s*2+1]);
    p_one_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({st[1] == DP_SLV && dslv[1] == SW'(s),
                st[0] == DP_SLV && dslv[0] == SW'(s)}));
    p_cpu_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (want[0][s] && want[1][s] && free[s]) |=>
        (st[0] == DP_SLV && dslv[0] == SW'(s) && st[1] == DP_WAIT));
    if (!DMA_MASK[s]) begin : g_fence
      p_dma_fence_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slv_hsel[s] |=> (st[0] == DP_SLV && dslv[0] == SW'(s)));
    end
  end
endmodule

// File: tb/ahb_dual_matrix_bench.sv
module ahb_dual_matrix_bench_mem #(
  parameter int ID = 0,
  parameter int WAITS = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hsel,
  input  logic [31:0] haddr,
  input  logic [1:0]  htrans,
  input  logic        hwrite,
  input  logic [31:0] hwdata,
  input  logic        hready,
  output logic [31:0] hrdata,
  output logic        hreadyout,
  output logic        hresp
);
  logic [31:0] mem [16];
  logic act, wr;
  logic [3:0] idx;
  int cnt;

  assign hreadyout = !(act && cnt != 0);
  assign hresp = 1'b0;
  assign hrdata = (act && !wr) ? mem[idx] : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'h5A00_0000 | (ID << 8) | i;
      act <= 1'b0; wr <= 1'b0; idx <= '0; cnt <= 0;
    end else begin
      if (act && hreadyout && wr) mem[idx] <= hwdata;
      if (hready) begin
        act <= hsel && htrans[1];
        wr <= hwrite;
        idx <= haddr[5:2];
        cnt <= WAITS;
      end else if (cnt != 0) begin
        cnt <= cnt - 1;
      end
    end
  end
endmodule

module ahb_dual_matrix_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = CLK_PERIOD / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] m_addr [2];
  logic [1:0]  m_trans [2];
  logic        m_write [2];
  logic [31:0] m_wdata [2];
  logic [31:0] cpu_hrdata, dma_hrdata;
  logic cpu_hready, cpu_hresp, dma_hready, dma_hresp;
  logic [7:0] slv_hsel, slv_hwrite, slv_hready, slv_hreadyout, slv_hresp;
  logic [255:0] slv_haddr, slv_hwdata, slv_hrdata;
  logic [15:0] slv_htrans;
  logic [23:0] slv_hsize;

  ahb_dual_matrix u_ahb_dual_matrix (
    .clk(clk), .rst_n(rst_n),
    .cpu_haddr(m_addr[0]), .cpu_htrans(m_trans[0]), .cpu_hwrite(m_write[0]),
    .cpu_hsize(3'd2), .cpu_hwdata(m_wdata[0]), .cpu_hrdata(cpu_hrdata),
    .cpu_hready(cpu_hready), .cpu_hresp(cpu_hresp),
    .dma_haddr(m_addr[1]), .dma_htrans(m_trans[1]), .dma_hwrite(m_write[1]),
    .dma_hsize(3'd2), .dma_hwdata(m_wdata[1]), .dma_hrdata(dma_hrdata),
    .dma_hready(dma_hready), .dma_hresp(dma_hresp),
    .slv_hsel(slv_hsel), .slv_haddr(slv_haddr), .slv_htrans(slv_htrans),
    .slv_hwrite(slv_hwrite), .slv_hsize(slv_hsize), .slv_hwdata(slv_hwdata),
    .slv_hready(slv_hready), .slv_hrdata(slv_hrdata),
    .slv_hreadyout(slv_hreadyout), .slv_hresp(slv_hresp)
  );

  for (genvar s = 0; s < 8; s++) begin : g_mem
    ahb_dual_matrix_bench_mem #(.ID(s), .WAITS(s == 1 ? 1 : (s == 6 ? 2 : 0))) u_mem (
      .clk(clk), .rst_n(rst_n), .hsel(slv_hsel[s]), .haddr(slv_haddr[s*32 +: 32]),
      .htrans(slv_htrans[s*2 +: 2]), .hwrite(slv_hwrite[s]), .hwdata(slv_hwdata[s*32 +: 32]),
      .hready(slv_hready[s]), .hrdata(slv_hrdata[s*32 +: 32]),
      .hreadyout(slv_hreadyout[s]), .hresp(slv_hresp[s]));
  end

  typedef struct { bit err; bit rd; logic [31:0] data; string tag; } exp_t;
  exp_t q0[$];
  exp_t q1[$];
  int checks = 0, fails = 0, cyc = 0;
  int done_cyc [2];
  bit sel_seen = 1'b0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] initval(int s, int i);
    return 32'h5A00_0000 | (s << 8) | i;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(int m, logic [31:0] a, bit wr, logic [31:0] wd,
                      bit err, logic [31:0] rd, string tag);
    exp_t e;
    e.err = err; e.rd = !wr; e.data = rd; e.tag = tag;
    m_addr[m] = a; m_trans[m] = 2'b10; m_write[m] = wr;
    if (m == 0) q0.push_back(e); else q1.push_back(e);
    forever begin
      #(Q);
      if ((m == 0 ? cpu_hready : dma_hready) === 1'b1) break;
      @(negedge clk);
    end
    @(negedge clk);
    m_trans[m] = 2'b00;
    if (wr) m_wdata[m] = wd;
  endtask

  task automatic drain();
    while (q0.size() != 0 || q1.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic monitor(int m);
    bit act = 1'b0, err1 = 1'b0;
    exp_t e;
    forever begin
      logic hr, rs;
      logic [31:0] d;
      @(negedge clk);
      #(Q);
      hr = (m == 0) ? cpu_hready : dma_hready;
      rs = (m == 0) ? cpu_hresp : dma_hresp;
      d  = (m == 0) ? cpu_hrdata : dma_hrdata;
      if (err1) check(hr && rs, "R5 error second cycle", {30'b0, hr, rs}, 32'h3);
      err1 = !hr && rs;
      if (hr) begin
        if (act) begin
          if ((m == 0 ? q0.size() : q1.size()) == 0) begin
            check(1'b0, "R9 unexpected completion", d, 32'h0);
          end else begin
            e = (m == 0) ? q0.pop_front() : q1.pop_front();
            done_cyc[m] = cyc;
            check(rs == e.err, e.tag, {31'b0, rs}, {31'b0, e.err});
            if (e.rd && !e.err) check(d == e.data, e.tag, d, e.data);
          end
        end
        act = m_trans[m][1];
      end
    end
  endtask

  initial begin
    wait (rst_n);
    fork monitor(0); monitor(1); join_none
  end

  initial begin
    forever begin
      @(negedge clk);
      #(Q);
      if (slv_hsel != 8'h00) sel_seen = 1'b1;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      m_addr[m] = '0; m_trans[m] = 2'b00; m_write[m] = 1'b0; m_wdata[m] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #(Q);
    check(cpu_hready && !cpu_hresp && dma_hready && !dma_hresp, "R10 master ports after reset",
          {28'b0, cpu_hready, cpu_hresp, dma_hready, dma_hresp}, 32'ha);
    check(slv_hsel == 8'h00, "R10 no select after reset", {24'b0, slv_hsel}, 32'h0);
    @(negedge clk);

    for (int s = 0; s < 8; s++)
      xfer(0, (s << 12) | (s << 2), 1'b0, 0, 1'b0, initval(s, s), "R4 R1 cpu read each port");
    drain();

    xfer(1, 32'h0000_0004, 1'b0, 0, 1'b0, initval(0, 1), "R1 dma read port0");
    xfer(1, 32'h0000_1004, 1'b0, 0, 1'b0, initval(1, 1), "R1 dma read port1");
    xfer(1, 32'h0000_2004, 1'b0, 0, 1'b0, initval(2, 1), "R1 dma read port2");
    xfer(1, 32'h0000_6004, 1'b0, 0, 1'b0, initval(6, 1), "R1 dma read port6");
    xfer(1, 32'h0000_7004, 1'b0, 0, 1'b0, initval(7, 1), "R1 dma read port7");
    drain();

    sel_seen = 1'b0;
    xfer(1, 32'h0000_3008, 1'b0, 0, 1'b1, 0, "R3 dma refused port3");
    xfer(1, 32'h0000_4008, 1'b1, 32'h1111_1111, 1'b1, 0, "R3 dma refused port4");
    xfer(1, 32'h0000_5008, 1'b0, 0, 1'b1, 0, "R3 dma refused port5");
    xfer(0, 32'h0001_0000, 1'b0, 0, 1'b1, 0, "R2 cpu unmapped");
    xfer(1, 32'h0000_8000, 1'b0, 0, 1'b1, 0, "R2 dma unmapped");
    drain();
    check(!sel_seen, "R2 R3 refused transfers select no port", {31'b0, sel_seen}, 32'h0);
    xfer(0, 32'h0000_4008, 1'b0, 0, 1'b0, initval(4, 2), "R3 port4 untouched by refused dma write");
    drain();

    fork
      xfer(0, 32'h0000_0010, 1'b0, 0, 1'b0, initval(0, 4), "R8 cpu parallel");
      xfer(1, 32'h0000_7010, 1'b0, 0, 1'b0, initval(7, 4), "R8 dma parallel");
    join
    drain();
    check(done_cyc[0] == done_cyc[1], "R8 same completion cycle", done_cyc[0], done_cyc[1]);

    fork
      xfer(0, 32'h0000_200C, 1'b1, 32'hDEAD_0001, 1'b0, 0, "R6 cpu write wins");
      xfer(1, 32'h0000_200C, 1'b0, 0, 1'b0, 32'hDEAD_0001, "R6 R7 dma held read sees cpu write");
    join
    drain();
    check(done_cyc[1] > done_cyc[0], "R7 dma completes after cpu", done_cyc[1], done_cyc[0] + 1);

    fork
      xfer(0, 32'h0000_0014, 1'b0, 0, 1'b0, initval(0, 5), "R9 cpu on fast port");
      xfer(1, 32'h0000_1014, 1'b0, 0, 1'b0, initval(1, 5), "R9 dma on slow port");
    join
    drain();
    check(done_cyc[1] == done_cyc[0] + 1, "R9 wait state stalls only owner", done_cyc[1], done_cyc[0] + 1);

    fork
      xfer(1, 32'h0000_601C, 1'b0, 0, 1'b0, initval(6, 7), "R6 dma owns port6");
      begin
        @(negedge clk);
        xfer(0, 32'h0000_6020, 1'b0, 0, 1'b0, initval(6, 8), "R6 R7 cpu waits for port6");
      end
    join
    drain();
    check(done_cyc[0] > done_cyc[1], "R6 grant held until owner completes", done_cyc[0], done_cyc[1] + 1);

    xfer(1, 32'h0000_1018, 1'b1, 32'h0BAD_F00D, 1'b0, 0, "R9 dma write port1");
    drain();
    xfer(0, 32'h0000_1018, 1'b0, 0, 1'b0, 32'h0BAD_F00D, "R9 cpu reads dma write");
    xfer(0, 32'h0000_6024, 1'b1, 32'hCAFE_0009, 1'b0, 0, "R1 cpu write port6");
    xfer(0, 32'h0000_6024, 1'b0, 0, 1'b0, 32'hCAFE_0009, "R1 cpu pipelined readback");
    drain();

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule